// File: doc/BRIEF.md
# Clock Generator Configuration I2C Slave

This block is the serial control port of a clock generator. It holds six 8-bit configuration registers and presents them as one 48-bit bus to the clock-enable and frequency logic of the chip. A host reaches the registers over a two-wire I2C bus at standard-mode rates. The block samples the bus lines with its own system clock. SDA is open-drain, so the block drives it only as a pull-low enable.

A host write always starts at register 0 and continues upward. After the address, two header bytes come first, a command code and a byte count. The block acknowledges both and discards their values. The data bytes follow, and the host may stop after any complete byte. A host read returns a byte count first and then the registers in ascending order. The host acknowledges every byte it wants to continue past and ends the read with a not-acknowledge.

Top module: `clk_cfg_i2c_slave`

## Requirements
- R1: After reset every bit of `regs_o` is 1 and `sda_oe_o` is 0.
- R2: Only the 8-bit address bytes 0xD2 (write) and 0xD3 (read) are acknowledged, which means the 7-bit address is 0x69 and bit 0 of the address byte is read/not-write. With any other address the block never pulls SDA low until the next start condition, and the registers keep their values.
- R3: In a write, the two bytes after the address are acknowledged and their values change no register.
- R4: In a write, the third and later bytes after the address load register 0, 1, 2 and so on in that order, and each one is acknowledged. Register k appears on `regs_o[8k+7:8k]`.
- R5: A stop condition after any complete byte ends the write. Registers already written keep their new values and the rest keep their old values.
- R6: In a write, data bytes after register 5 are acknowledged and change no register.
- R7: In a read, the block sends the value 6, then registers 0 through 5, each MSB first. Bytes after register 5 read as 0xFF.
- R8: A host not-acknowledge ends a read. From the falling SCL edge after that bit until the next start, the block leaves SDA released.
- R9: A start or stop condition is an SDA edge while SCL is high. A repeated start at any point begins a new address phase, and the next write begins again at register 0.
- R10: The block changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock used to sample the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| regs_o | output | 48 | Register contents, register k in bits 8k+7:8k |

## Verification
The assertions assume that every SCL high or low phase lasts well beyond the two-flop sampling delay plus one cycle. They also assume that the host changes SDA only while SCL is low, except for start and stop conditions. The SDA-drive rule and the idle-release rule depend on these. The bench host holds each quarter bit for eight system clocks and moves SDA only in the middle of the low phase. The random transfer lengths, data values and bad addresses are drawn inside these timing rules, so no stimulus breaks the bus protocol.

// File: rtl/clk_cfg_pkg.sv
package clk_cfg_pkg;
  localparam int unsigned REG_W        = 8;
  localparam int unsigned NUM_REGS_DEF = 6;
  localparam logic [6:0]  DEV_ADDR_DEF = 7'h69;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_ACK
  } slv_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sr, sda_sr;
  logic scl_q, sda_q, scl_s, sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[STAGES-2:0], scl_i};
      sda_sr <= {sda_sr[STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_s      = scl_sr[STAGES-1];
  assign sda_s      = sda_sr[STAGES-1];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  // SDA edge while SCL held high
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import clk_cfg_pkg::*;
#(
  parameter int unsigned NUM_REGS = NUM_REGS_DEF,
  parameter int unsigned IDX_W    = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [IDX_W-1:0]          wr_idx_i,
  input  logic [REG_W-1:0]          wr_data_i,
  input  logic [IDX_W-1:0]          rd_idx_i,
  output logic [REG_W-1:0]          rd_data_o,
  output logic [NUM_REGS*REG_W-1:0] regs_o
);
  logic [REG_W-1:0] regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  regs_q[g] <= '1;
      else if (we_i && wr_idx_i == IDX_W'(g))       regs_q[g] <= wr_data_i;
    end
    assign regs_o[g*REG_W +: REG_W] = regs_q[g];
  end

  always_comb begin
    rd_data_o = '1;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_idx_i == IDX_W'(i)) rd_data_o = regs_q[i];
  end
endmodule

// File: rtl/i2c_block_fsm.sv
module i2c_block_fsm
  import clk_cfg_pkg::*;
#(
  parameter int unsigned NUM_REGS = NUM_REGS_DEF,
  parameter logic [6:0]  DEV_ADDR = DEV_ADDR_DEF,
  parameter int unsigned IDX_W    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             sda_i,
  input  logic [REG_W-1:0] rd_data_i,
  output logic             sda_oe_o,
  output logic             we_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [REG_W-1:0] wr_data_o,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             idle_o
);
  localparam int unsigned    BIT_W      = $clog2(REG_W + 1);
  localparam int unsigned    HDR_BYTES  = 2;
  localparam int unsigned    BC_MAX     = NUM_REGS + HDR_BYTES;
  localparam logic [REG_W-1:0] COUNT_BYTE = REG_W'(NUM_REGS);

  slv_state_e       state_q;
  logic [BIT_W-1:0] bit_q;
  logic [REG_W-1:0] rx_q, tx_q, wdat_q;
  logic [IDX_W-1:0] byte_q, widx_q;
  logic             rw_q, nack_q, oe_q, we_q;
  logic             byte_done;

  assign byte_done = scl_fall_i && (bit_q == BIT_W'(REG_W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      byte_q  <= '0;
      rw_q    <= 1'b0;
      nack_q  <= 1'b0;
      oe_q    <= 1'b0;
      we_q    <= 1'b0;
      widx_q  <= '0;
      wdat_q  <= '0;
    end else begin
      we_q <= 1'b0;
      if (start_i) begin
        state_q <= ST_ADDR;
        bit_q   <= '0;
        oe_q    <= 1'b0;
      end else if (stop_i) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR: begin
            if (scl_rise_i) begin
              rx_q  <= {rx_q[REG_W-2:0], sda_i};
              bit_q <= bit_q + 1'b1;
            end else if (byte_done) begin
              if (rx_q[7:1] == DEV_ADDR) begin
                oe_q    <= 1'b1;
                rw_q    <= rx_q[0];
                state_q <= ST_ADDR_ACK;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall_i) begin
              byte_q <= '0;
              bit_q  <= '0;
              if (rw_q) begin
                tx_q    <= COUNT_BYTE;
                oe_q    <= ~COUNT_BYTE[REG_W-1];
                state_q <= ST_RD_BYTE;
              end else begin
                oe_q    <= 1'b0;
                state_q <= ST_WR_BYTE;
              end
            end
          end
          ST_WR_BYTE: begin
            if (scl_rise_i) begin
              rx_q  <= {rx_q[REG_W-2:0], sda_i};
              bit_q <= bit_q + 1'b1;
            end else if (byte_done) begin
              oe_q    <= 1'b1;
              state_q <= ST_WR_ACK;
              // header bytes and overflow bytes are acked but dropped
              if (byte_q >= IDX_W'(HDR_BYTES) && byte_q < IDX_W'(BC_MAX)) begin
                we_q   <= 1'b1;
                widx_q <= byte_q - IDX_W'(HDR_BYTES);
                wdat_q <= rx_q;
              end
              if (byte_q != IDX_W'(BC_MAX)) byte_q <= byte_q + 1'b1;
            end
          end
          ST_WR_ACK: begin
            if (scl_fall_i) begin
              oe_q    <= 1'b0;
              bit_q   <= '0;
              state_q <= ST_WR_BYTE;
            end
          end
          ST_RD_BYTE: begin
            if (scl_rise_i) begin
              bit_q <= bit_q + 1'b1;
            end else if (byte_done) begin
              oe_q    <= 1'b0;
              state_q <= ST_RD_ACK;
            end else if (scl_fall_i) begin
              tx_q <= {tx_q[REG_W-2:0], 1'b0};
              oe_q <= ~tx_q[REG_W-2];
            end
          end
          ST_RD_ACK: begin
            if (scl_rise_i) begin
              nack_q <= sda_i;
            end else if (scl_fall_i) begin
              if (nack_q) begin
                oe_q    <= 1'b0;
                state_q <= ST_IDLE;
              end else begin
                tx_q    <= rd_data_i;
                oe_q    <= ~rd_data_i[REG_W-1];
                bit_q   <= '0;
                state_q <= ST_RD_BYTE;
                if (byte_q != IDX_W'(NUM_REGS)) byte_q <= byte_q + 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o  = oe_q;
  assign we_o      = we_q;
  assign wr_idx_o  = widx_q;
  assign wr_data_o = wdat_q;
  assign rd_idx_o  = byte_q;
  assign idle_o    = (state_q == ST_IDLE);
endmodule

// File: rtl/clk_cfg_i2c_slave.sv
module clk_cfg_i2c_slave
  import clk_cfg_pkg::*;
#(
  parameter int unsigned NUM_REGS    = NUM_REGS_DEF,
  parameter logic [6:0]  DEV_ADDR    = DEV_ADDR_DEF,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      scl_i,
  input  logic                      sda_i,
  output logic                      sda_oe_o,
  output logic [NUM_REGS*REG_W-1:0] regs_o
);
  localparam int unsigned IDX_W = $clog2(NUM_REGS + 3);

  logic             sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic             reg_we, fsm_idle;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [REG_W-1:0] wr_data, rd_data;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2c_block_fsm #(.NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR), .IDX_W(IDX_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .sda_i      (sda_s),
    .rd_data_i  (rd_data),
    .sda_oe_o   (sda_oe_o),
    .we_o       (reg_we),
    .wr_idx_o   (wr_idx),
    .wr_data_o  (wr_data),
    .rd_idx_o   (rd_idx),
    .idle_o     (fsm_idle)
  );

  cfg_reg_bank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_data),
    .rd_idx_i  (rd_idx),
    .rd_data_o (rd_data),
    .regs_o    (regs_o)
  );
endmodule

// File: rtl/clk_cfg_i2c_slave_chk.sv
module clk_cfg_i2c_slave_chk #(
  parameter int unsigned NUM_REGS = 6,
  parameter int unsigned REG_W    = 8,
  parameter int unsigned IDX_W    = 4
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      scl_i,
  input logic                      sda_oe_o,
  input logic [NUM_REGS*REG_W-1:0] regs_o,
  input logic                      reg_we,
  input logic [IDX_W-1:0]          wr_idx,
  input logic                      fsm_idle
);
  assert_reset_ones_R1: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (regs_o == '1 && !sda_oe_o));

  assert_drive_scl_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_i);

  // registers move only on a write strobe (header bytes and bad addresses give none)
  assert_regs_only_on_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(regs_o) |-> $past(reg_we));

  assert_write_in_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we |-> (wr_idx < IDX_W'(NUM_REGS)));

  assert_idle_released_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsm_idle |-> !sda_oe_o);
endmodule

bind clk_cfg_i2c_slave clk_cfg_i2c_slave_chk #(
  .NUM_REGS (NUM_REGS),
  .REG_W    (clk_cfg_pkg::REG_W),
  .IDX_W    (IDX_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .scl_i    (scl_i),
  .sda_oe_o (sda_oe_o),
  .regs_o   (regs_o),
  .reg_we   (reg_we),
  .wr_idx   (wr_idx),
  .fsm_idle (fsm_idle)
);

// File: tb/clk_cfg_i2c_slave_test.sv
module clk_cfg_i2c_slave_test;
  localparam int NREG = 6;
  localparam int QT   = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic scl = 1'b1;
  logic sda_host = 1'b1;
  logic sda_oe;
  logic sda_bus;
  logic [NREG*8-1:0] regs;

  int checks = 0;
  int failures = 0;
  logic [7:0] mdl [NREG];
  logic [7:0] wbuf [16];

  always #2.5 clk = ~clk;
  assign sda_bus = sda_host & ~sda_oe;

  clk_cfg_i2c_slave uut (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .scl_i    (scl),
    .sda_i    (sda_bus),
    .sda_oe_o (sda_oe),
    .regs_o   (regs)
  );

  function automatic logic [NREG*8-1:0] exp_regs();
    logic [NREG*8-1:0] v;
    for (int i = 0; i < NREG; i++) v[i*8 +: 8] = mdl[i];
    return v;
  endfunction

  function automatic logic [7:0] exp_rd(input int i);
    return (i < NREG) ? mdl[i] : 8'hFF;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n = 1);
    repeat (n * QT) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_host = 1'b1; wq();
    scl = 1'b1; wq();
    sda_host = 1'b0; wq();
    scl = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    sda_host = 1'b0; wq();
    scl = 1'b1; wq();
    sda_host = 1'b1; wq();
  endtask

  task automatic send_bit(input logic b);
    sda_host = b; wq();
    scl = 1'b1; wq(2);
    scl = 1'b0; wq();
  endtask

  task automatic recv_bit(output logic b);
    sda_host = 1'b1; wq();
    scl = 1'b1; wq();
    b = sda_bus; wq();
    scl = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(nack);
  endtask

  task automatic do_write(input int n);
    logic ack;
    i2c_start();
    send_byte(8'hD2, ack);               chk("R2 write addr ack", ack, 1);
    send_byte(8'($urandom), ack);        chk("R3 cmd ack", ack, 1);
    send_byte(8'($urandom), ack);        chk("R3 count ack", ack, 1);
    chk("R3 header no change", regs, exp_regs());
    for (int i = 0; i < n; i++) begin
      wbuf[i] = 8'($urandom);
      send_byte(wbuf[i], ack);
      if (i < NREG) begin
        mdl[i] = wbuf[i];
        chk("R4 data ack", ack, 1);
      end else begin
        chk("R6 extra ack", ack, 1);
      end
    end
    i2c_stop();
    wq();
    if (n < NREG) chk("R5 partial write", regs, exp_regs());
    else          chk("R4 R6 full write", regs, exp_regs());
  endtask

  task automatic do_read(input int n);
    logic ack;
    logic [7:0] d;
    i2c_start();
    send_byte(8'hD3, ack);          chk("R2 read addr ack", ack, 1);
    recv_byte(n == 0, d);           chk("R7 byte count", d, 8'd6);
    for (int i = 0; i < n; i++) begin
      recv_byte(i == n - 1, d);
      chk("R7 read data", d, exp_rd(i));
    end
    chk("R8 released after nack", sda_oe, 1'b0);
    i2c_stop();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] d;
    logic [6:0] bad;
    void'($urandom(32'd4711));
    for (int i = 0; i < NREG; i++) mdl[i] = 8'hFF;
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 reset regs", regs, {(NREG*8){1'b1}});
    chk("R1 reset sda", sda_oe, 1'b0);

    // directed cases
    do_read(NREG + 1);          // R7 defaults and overflow read
    do_write(NREG);             // R4
    do_read(NREG);              // R7
    do_write(2);                // R5
    do_write(NREG + 3);         // R6
    do_read(2);                 // R8 early nack

    // R2: foreign address
    bad = 7'($urandom);
    if (bad == 7'h69) bad = 7'h12;
    i2c_start();
    send_byte({bad, 1'b0}, ack);  chk("R2 foreign addr nack", ack, 0);
    send_byte(8'h00, ack);        chk("R2 foreign data nack", ack, 0);
    i2c_stop(); wq();
    chk("R2 regs unchanged", regs, exp_regs());

    // R9: repeated start restarts write at register 0
    i2c_start();
    send_byte(8'hD2, ack); send_byte(8'h00, ack); send_byte(8'h06, ack);
    send_byte(8'hA5, ack); mdl[0] = 8'hA5;
    i2c_start();
    send_byte(8'hD2, ack);        chk("R9 restart addr ack", ack, 1);
    send_byte(8'h00, ack); send_byte(8'h06, ack);
    send_byte(8'h3C, ack); mdl[0] = 8'h3C;
    i2c_stop(); wq();
    chk("R9 restart byte0", regs, exp_regs());

    // R9: write header then repeated start into read
    i2c_start();
    send_byte(8'hD2, ack); send_byte(8'h00, ack);
    i2c_start();
    send_byte(8'hD3, ack);        chk("R9 restart read ack", ack, 1);
    recv_byte(1'b0, d);           chk("R9 restart count", d, 8'd6);
    recv_byte(1'b1, d);           chk("R9 restart data0", d, mdl[0]);
    i2c_stop();

    // random mix
    for (int it = 0; it < 20; it++) begin
      if ($urandom % 2 == 0) do_write(int'($urandom % 9));
      else                   do_read(int'($urandom % 8));
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule